// File: doc/BRIEF.md
# Indexed Colour Palette Lookup Stage

This block turns a stream of 8-bit frame-buffer pixels into 24-bit RGB video words. Every pixel can be decoded one of two ways. In direct decoding the byte is read as packed red, green and blue fields and each field is widened to a full 8-bit channel. In indexed decoding the byte addresses a 256-entry colour table and the 24-bit word stored there becomes the output colour, so an image can use any 256 colours picked from the full 24-bit space.

A host port loads table entries one at a time, and may do so while pixels are streaming. The decoding in force is latched from the mode select only on the first pixel of a frame, so one frame is never split between the two decodings. Both decodings reach the output after the same fixed delay, and the valid and start-of-frame flags travel alongside the colour.

Top module: `colour_index_stage`

## Requirements
- R1: While reset is held and after it is released with no pixel driven, `rgb_valid_o` and `rgb_sof_o` are 0 and `rgb_o` is 0.
- R2: `rgb_valid_o` equals `pix_valid_i` from exactly two clock edges earlier, and `rgb_sof_o` equals `pix_valid_i & pix_sof_i` from two edges earlier, in both decodings.
- R3: In direct decoding, red is bits [7:5], green bits [4:2] and blue bits [1:0] of the pixel; each 3-bit field f becomes {f, f, f[2:1]} and the 2-bit blue field b becomes {b, b, b, b}; the output word is {red, green, blue} with red in bits [23:16].
- R4: In direct decoding pixel 0x00 gives 0x000000 and pixel 0xFF gives 0xFFFFFF.
- R5: In indexed decoding the output word is the table entry addressed by the pixel byte.
- R6: A table write (`pal_we_i` with `pal_addr_i`, `pal_data_i`) is seen by every pixel presented in a later cycle.
- R7: A pixel presented in the same cycle as a write to its own entry receives the entry's previous contents.
- R8: `mode_sel_i` (1 = indexed, 0 = direct) is taken only with a valid pixel that has `pix_sof_i` high; that pixel and all following ones use it until the next such pixel; changes at other times have no effect. After reset the decoding is direct.
- R9: Whenever `rgb_valid_o` is 0, `rgb_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel_i | input | 1 | Decoding request, 1 indexed, 0 direct; taken at frame start |
| pix_valid_i | input | 1 | Pixel byte present this cycle |
| pix_sof_i | input | 1 | Marks the first pixel of a frame |
| pix_data_i | input | 8 | Frame-buffer pixel byte |
| pal_we_i | input | 1 | Table write strobe |
| pal_addr_i | input | 8 | Table entry to write |
| pal_data_i | input | 24 | Colour word to store, red in [23:16] |
| rgb_valid_o | output | 1 | Output colour present |
| rgb_sof_o | output | 1 | Output colour is the first of a frame |
| rgb_o | output | 24 | Output colour, red [23:16], green [15:8], blue [7:0] |

## Verification
The hardest situation to reach is a table write landing on the very entry that a pixel reads in the same cycle, and then again on the cycle after, because random addresses rarely coincide. The stimulus forces this with a directed pair of cycles that write one entry while the stream reads it twice, and the random phase writes to the table on about one cycle in eight while pixels from a small set of hot indices flow, so coincidences recur. Mode-select changes in the middle of a frame are driven both directed and at random to show they wait for the next frame start.

// File: rtl/colour_pkg.sv
package colour_pkg;
    localparam int PIX_W = 8;
    localparam int CH_W  = 8;
    localparam int RGB_W = 3 * CH_W;

    typedef enum logic {
        DEC_DIRECT  = 1'b0,
        DEC_INDEXED = 1'b1
    } dec_mode_e;
endpackage

// File: rtl/palette_ram.sv
module palette_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    // Read sees the old word when a write hits the same entry this edge.
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
        if (re_i) begin
            rdata_q <= mem[raddr_i];
        end
    end

    assign rdata_o = rdata_q;

    // R6: a word written one edge earlier is returned to the next read
    p_wr_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (re_i && $past(we_i) && raddr_i == $past(waddr_i))
        |=> rdata_o == $past(wdata_i, 2));
endmodule

// File: rtl/direct_decode.sv
module direct_decode #(
    parameter int PIX_W  = 8,
    parameter int CH_W   = 8,
    parameter int R_BITS = 3,
    parameter int G_BITS = 3,
    parameter int B_BITS = 2
) (
    input  logic [PIX_W-1:0]  pix_i,
    output logic [3*CH_W-1:0] rgb_o
);
    localparam int G_LSB = B_BITS;
    localparam int R_LSB = B_BITS + G_BITS;

    logic [R_BITS-1:0] r_fld;
    logic [G_BITS-1:0] g_fld;
    logic [B_BITS-1:0] b_fld;
    logic [CH_W-1:0]   r_ch, g_ch, b_ch;

    assign r_fld = pix_i[R_LSB +: R_BITS];
    assign g_fld = pix_i[G_LSB +: G_BITS];
    assign b_fld = pix_i[0 +: B_BITS];

    // Repeat each field from its MSB down to fill the channel width.
    always_comb begin
        for (int i = 0; i < CH_W; i++) begin
            r_ch[i] = r_fld[R_BITS-1 - ((CH_W-1-i) % R_BITS)];
            g_ch[i] = g_fld[G_BITS-1 - ((CH_W-1-i) % G_BITS)];
            b_ch[i] = b_fld[B_BITS-1 - ((CH_W-1-i) % B_BITS)];
        end
    end

    assign rgb_o = {r_ch, g_ch, b_ch};
endmodule

// File: rtl/colour_index_stage.sv
module colour_index_stage
    import colour_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sel_i,
    input  logic             pix_valid_i,
    input  logic             pix_sof_i,
    input  logic [PIX_W-1:0] pix_data_i,
    input  logic             pal_we_i,
    input  logic [PIX_W-1:0] pal_addr_i,
    input  logic [RGB_W-1:0] pal_data_i,
    output logic             rgb_valid_o,
    output logic             rgb_sof_o,
    output logic [RGB_W-1:0] rgb_o
);
    typedef struct packed {
        logic             s1_valid;
        logic             s1_sof;
        dec_mode_e        s1_mode;
        logic [PIX_W-1:0] s1_pix;
        dec_mode_e        frame_mode;
        logic             out_valid;
        logic             out_sof;
        logic [RGB_W-1:0] out_rgb;
        logic [1:0]       cyc;
    } state_t;

    state_t st_d, st_q;

    logic [RGB_W-1:0] pal_rd;
    logic [RGB_W-1:0] dir_rgb;
    logic             frame_start;
    dec_mode_e        eff_mode;

    palette_ram #(
        .ADDR_W (PIX_W),
        .DATA_W (RGB_W)
    ) i_palette_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (pal_we_i),
        .waddr_i (pal_addr_i),
        .wdata_i (pal_data_i),
        .re_i    (pix_valid_i),
        .raddr_i (pix_data_i),
        .rdata_o (pal_rd)
    );

    direct_decode #(
        .PIX_W  (PIX_W),
        .CH_W   (CH_W),
        .R_BITS (3),
        .G_BITS (3),
        .B_BITS (2)
    ) i_direct_decode (
        .pix_i (st_q.s1_pix),
        .rgb_o (dir_rgb)
    );

    assign frame_start = pix_valid_i && pix_sof_i;
    assign eff_mode    = frame_start ? dec_mode_e'(mode_sel_i) : st_q.frame_mode;

    always_comb begin
        st_d = st_q;
        // stage 1: capture pixel and its frame decoding
        st_d.frame_mode = eff_mode;
        st_d.s1_valid   = pix_valid_i;
        st_d.s1_sof     = frame_start;
        st_d.s1_mode    = eff_mode;
        if (pix_valid_i) begin
            st_d.s1_pix = pix_data_i;
        end
        // stage 2: select colour source
        st_d.out_valid = st_q.s1_valid;
        st_d.out_sof   = st_q.s1_sof;
        if (!st_q.s1_valid) begin
            st_d.out_rgb = '0;
        end else if (st_q.s1_mode == DEC_INDEXED) begin
            st_d.out_rgb = pal_rd;
        end else begin
            st_d.out_rgb = dir_rgb;
        end
        if (st_q.cyc != 2'd2) begin
            st_d.cyc = st_q.cyc + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rgb_valid_o = st_q.out_valid;
    assign rgb_sof_o   = st_q.out_sof;
    assign rgb_o       = st_q.out_rgb;

    // R2: output valid trails input valid by exactly two edges
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cyc == 2'd2) |-> rgb_valid_o == $past(pix_valid_i, 2));

    // R2: frame start flag only accompanies a valid colour
    p_sof_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rgb_sof_o |-> rgb_valid_o);

    // R9: idle output carries a zero colour
    p_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rgb_valid_o |-> rgb_o == '0);

    // R8: frame decoding only changes after a frame-start pixel
    p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cyc != 2'd0 && st_q.frame_mode != $past(st_q.frame_mode))
        |-> $past(pix_valid_i && pix_sof_i));
endmodule

// File: tb/test_colour_index_stage.sv
module test_colour_index_stage;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_sel_i, pix_valid_i, pix_sof_i, pal_we_i;
    logic [7:0]  pix_data_i, pal_addr_i;
    logic [23:0] pal_data_i;
    logic        rgb_valid_o, rgb_sof_o;
    logic [23:0] rgb_o;

    colour_index_stage i_colour_index_stage (
        .clk (clk), .rst_n (rst_n), .mode_sel_i (mode_sel_i),
        .pix_valid_i (pix_valid_i), .pix_sof_i (pix_sof_i), .pix_data_i (pix_data_i),
        .pal_we_i (pal_we_i), .pal_addr_i (pal_addr_i), .pal_data_i (pal_data_i),
        .rgb_valid_o (rgb_valid_o), .rgb_sof_o (rgb_sof_o), .rgb_o (rgb_o)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [23:0] pal_m [256];
    logic        fmode_m;
    logic        h_v [2];
    logic        h_s [2];
    logic [23:0] h_rgb [2];
    string       h_tag [2];

    function automatic logic [23:0] expand332(input logic [7:0] p);
        logic [2:0] r = p[7:5];
        logic [2:0] g = p[4:2];
        logic [1:0] b = p[1:0];
        return {r, r, r[2:1], g, g, g[2:1], b, b, b, b};
    endfunction

    function automatic logic [23:0] init_word(input int i);
        logic [7:0] k = 8'(i);
        return {k ^ 8'h5A, ~k, 8'(k * 8'd37)};
    endfunction

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // One cycle: check output of two cycles ago, predict, then drive.
    task automatic step(input logic v, input logic s, input logic m, input logic [7:0] p,
                        input logic we, input logic [7:0] wa, input logic [23:0] wd,
                        input string tag);
        logic [23:0] e;
        logic        em;
        @(negedge clk);
        check("R2", {23'd0, rgb_valid_o}, {23'd0, h_v[1]});
        check("R2", {23'd0, rgb_sof_o}, {23'd0, h_s[1]});
        check(h_tag[1], rgb_o, h_rgb[1]);
        h_v[1] = h_v[0]; h_s[1] = h_s[0]; h_rgb[1] = h_rgb[0]; h_tag[1] = h_tag[0];
        if (v && s) fmode_m = m;
        em = fmode_m;
        e  = !v ? 24'd0 : (em ? pal_m[p] : expand332(p));
        h_v[0] = v; h_s[0] = v & s; h_rgb[0] = e;
        h_tag[0] = (tag != "") ? tag : (!v ? "R9" : (em ? "R5" : "R3"));
        if (we) pal_m[wa] = wd;
        pix_valid_i = v; pix_sof_i = s; mode_sel_i = m; pix_data_i = p;
        pal_we_i = we; pal_addr_i = wa; pal_data_i = wd;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        mode_sel_i = 0; pix_valid_i = 0; pix_sof_i = 0; pix_data_i = 0;
        pal_we_i = 0; pal_addr_i = 0; pal_data_i = 0;
        fmode_m = 0;
        for (int i = 0; i < 2; i++) begin
            h_v[i] = 0; h_s[i] = 0; h_rgb[i] = 0; h_tag[i] = "R1";
        end
        repeat (3) @(negedge clk);
        check("R1", {22'd0, rgb_valid_o, rgb_sof_o}, 24'd0);
        check("R1", rgb_o, 24'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {22'd0, rgb_valid_o, rgb_sof_o}, 24'd0);
        check("R1", rgb_o, 24'd0);

        // load the table
        for (int i = 0; i < 256; i++) step(0, 0, 0, 0, 1, 8'(i), init_word(i), "R1");

        // direct frame with mode forced direct after reset default
        step(1, 1, 0, 8'h00, 0, 0, 0, "R4");
        step(1, 0, 0, 8'hFF, 0, 0, 0, "R4");
        step(1, 0, 0, 8'hE0, 0, 0, 0, "R3");
        step(1, 0, 0, 8'h1C, 0, 0, 0, "R3");
        step(1, 0, 0, 8'h03, 0, 0, 0, "R3");
        step(1, 0, 1, 8'h42, 0, 0, 0, "R8");
        step(0, 1, 1, 8'h42, 0, 0, 0, "R8");
        step(1, 0, 1, 8'h42, 0, 0, 0, "R8");
        // indexed frame
        step(1, 1, 1, 8'h42, 0, 0, 0, "R5");
        step(1, 0, 1, 8'h00, 0, 0, 0, "R5");
        step(1, 0, 0, 8'hFF, 0, 0, 0, "R8");
        // same-cycle write then next-cycle read
        step(1, 0, 0, 8'h10, 1, 8'h10, 24'hC0FFEE, "R7");
        step(1, 0, 0, 8'h10, 0, 0, 0, "R6");
        step(1, 0, 0, 8'h10, 1, 8'h10, 24'h123456, "R7");
        step(0, 0, 0, 8'h10, 0, 0, 0, "R9");
        step(1, 0, 0, 8'h10, 0, 0, 0, "R6");

        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic       v  = ($urandom % 4) != 0;
            logic       s  = ($urandom % 48) == 0;
            logic       m  = 1'($urandom);
            logic [7:0] hot = 8'($urandom % 4);
            logic [7:0] p  = ($urandom % 2) ? hot : 8'($urandom);
            logic       we = ($urandom % 8) == 0;
            logic [7:0] wa = ($urandom % 2) ? hot : 8'($urandom);
            step(v, s, m, p, we, wa, 24'($urandom), "");
        end
        repeat (3) step(0, 0, 0, 0, 0, 0, 0, "R9");
        finish_run();
    end
endmodule